// File: doc/BRIEF.md
# Verify-Retry Bidirectional Write Controller

This block runs the write sequence for one word of a spin-torque magnetic memory array. On a host request it first reads the stored word and works out which bits must change. Bits going from 1 to 0 and bits going from 0 to 1 need opposite current directions through the cell, so they are handled as two separate sets. All of the 1-to-0 set is written before any of the 0-to-1 set. Bits that do not change are never pulsed.

Each set is cut into groups of at most `GRP_MAX` bits, taken from the lowest pending bit upward. Each group gets a write pulse followed by a verify read. The next pulse goes only to the bits that failed verify. This repeats until the group passes or the configured pulse budget is used up. When the budget runs out, the operation stops with an error flag and reports the bits that still fail. The array command port carries the pulse polarity, the bit mask, the bit-line and source-line drive and a word-line voltage select for each polarity. The configuration is latched when a request is accepted.

Top module: `mram_wr_ctrl`

## Requirements
- R1: A request is accepted when `req_i` is high while `busy_o` is low. The first array command after acceptance is a read (`arr_cmd_o` = 1) at the requested address.
- R2: If the stored word equals the request data, the operation finishes with `done_o` and no error, and no pulse command (`arr_cmd_o` = 2) is issued.
- R3: Bits stored as 1 and requested as 0 are pulsed with `arr_pol_o` = 0. During such a pulse `arr_bl_o` = 1, `arr_sl_o` = 0, and `arr_vsel_o` equals the write-0 level latched at acceptance.
- R4: Bits stored as 0 and requested as 1 are pulsed with `arr_pol_o` = 1. During such a pulse `arr_bl_o` = 0, `arr_sl_o` = 1, and `arr_vsel_o` equals the latched write-1 level.
- R5: A pulse mask only ever contains bits whose stored value differs from the requested value.
- R6: Within one operation, no polarity-0 pulse follows a polarity-1 pulse.
- R7: A new group holds the lowest `GRP_MAX` pending bits of the current polarity, or all of them if fewer remain. A pulse mask is never empty.
- R8: Every pulse is followed directly by a verify read (`arr_cmd_o` = 3). A repeat pulse covers exactly the group bits that read back wrong at the last verify.
- R9: A group receives at most `cfg_max_pulse_i` pulses, the value latched at acceptance, with 0 treated as 1.
- R10: If a group still fails after its last allowed pulse, the operation ends with `done_o` and `err_o` high and `fail_mask_o` holding the failing bits. No further array command is issued. On success `fail_mask_o` is zero.
- R11: A successful operation raises `done_o` for exactly one cycle with `err_o` low, and the array word then holds the request data.
- R12: A non-idle array command, with its address, mask and polarity, stays constant until the cycle in which `arr_ack_i` is high.
- R13: `busy_o` is high while any array command is outstanding. It is low in the `done_o` cycle and afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, taken while idle |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | DATA_W | New word value |
| cfg_max_pulse_i | input | PULSE_W | Pulse budget per group (0 acts as 1) |
| cfg_vsel_w0_i | input | VSEL_W | Word-line level code for polarity 0 |
| cfg_vsel_w1_i | input | VSEL_W | Word-line level code for polarity 1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last operation ran out of pulses |
| fail_mask_o | output | DATA_W | Bits still failing on error |
| arr_cmd_o | output | 2 | 0 idle, 1 read, 2 pulse, 3 verify |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_mask_o | output | DATA_W | Bits pulsed (zero outside pulses) |
| arr_pol_o | output | 1 | Pulse polarity (value written) |
| arr_bl_o | output | 1 | Bit line driven high |
| arr_sl_o | output | 1 | Source line driven high |
| arr_vsel_o | output | VSEL_W | Word-line level select during pulse |
| arr_ack_i | input | 1 | Array accepted command; read data valid |
| arr_rdata_i | input | DATA_W | Read / verify data |

## Verification
The bench models an array word whose cells each need a set number of pulses before they flip. From that model it predicts every pulse mask, the final word and the error outcome. The sweeps cover many old and new word pairs with varying acknowledge latency. A design that pulsed unchanged bits, mixed the polarities or built groups from the wrong end would show up as a mismatch in the pulse sequence. A design that re-pulsed the whole group instead of only the failing bits would also break the sequence, as would one that miscounted the pulse budget or did not treat a zero budget as one. Targeted cases exercise:
- An unchanged word, where any pulse is a fault.
- Errors in the first polarity phase, where a design that keeps going would issue extra commands.
- Configuration inputs changed mid-operation, which catch a design that does not latch them.

// File: rtl/mram_wr_pkg.sv
package mram_wr_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_READ   = 2'd1,
    CMD_PULSE  = 2'd2,
    CMD_VERIFY = 2'd3
  } arr_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_PICK,
    S_PULSE,
    S_VERIFY
  } wr_state_e;
endpackage

// File: rtl/mram_wr_split.sv
module mram_wr_split #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] nxt_i,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] set_o,
  output logic              none_o
);
  assign clr_o  = cur_i & ~nxt_i;
  assign set_o  = ~cur_i & nxt_i;
  assign none_o = (cur_i == nxt_i);
endmodule

// File: rtl/mram_wr_grp_pick.sv
module mram_wr_grp_pick #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GRP_MAX = 8
) (
  input  logic [DATA_W-1:0] pend_i,
  output logic [DATA_W-1:0] grp_o,
  output logic [DATA_W-1:0] rest_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GRP_MAX);

  logic [CNT_W-1:0] cnt;

  // lowest set bits first, up to LIMIT of them
  always_comb begin
    cnt   = '0;
    grp_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (pend_i[i] && (cnt < LIMIT)) begin
        grp_o[i] = 1'b1;
        cnt      = cnt + CNT_W'(1);
      end
    end
  end

  assign rest_o = pend_i & ~grp_o;
endmodule

// File: rtl/mram_wr_verify.sv
module mram_wr_verify #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] act_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] fail_o,
  output logic              pass_o
);
  assign fail_o = act_i & (rdata_i ^ {DATA_W{pol_i}});
  assign pass_o = ~|fail_o;
endmodule

// File: rtl/mram_wr_ctrl.sv
module mram_wr_ctrl
  import mram_wr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned GRP_MAX = 8,
  parameter int unsigned PULSE_W = 4,
  parameter int unsigned VSEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [PULSE_W-1:0] cfg_max_pulse_i,
  input  logic [VSEL_W-1:0] cfg_vsel_w0_i,
  input  logic [VSEL_W-1:0] cfg_vsel_w1_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] fail_mask_o,
  output logic [1:0]        arr_cmd_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_mask_o,
  output logic              arr_pol_o,
  output logic              arr_bl_o,
  output logic              arr_sl_o,
  output logic [VSEL_W-1:0] arr_vsel_o,
  input  logic              arr_ack_i,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  localparam logic [PULSE_W-1:0] ONE_PULSE = PULSE_W'(1);

  wr_state_e          state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  pend0_q, pend1_q, act_q, fail_q;
  logic [PULSE_W-1:0] max_q, tries_q;
  logic [VSEL_W-1:0]  vsel0_q, vsel1_q;
  logic               pol_q, done_q, err_q;

  logic [DATA_W-1:0]  clr_mask, set_mask, pick_src, grp, rest, vfy_fail;
  logic               no_change, vfy_pass, pulsing;
  arr_cmd_e           cmd;

  mram_wr_split #(.DATA_W(DATA_W)) u_split (
    .cur_i  (arr_rdata_i),
    .nxt_i  (data_q),
    .clr_o  (clr_mask),
    .set_o  (set_mask),
    .none_o (no_change)
  );

  assign pick_src = pol_q ? pend1_q : pend0_q;

  mram_wr_grp_pick #(.DATA_W(DATA_W), .GRP_MAX(GRP_MAX)) u_pick (
    .pend_i (pick_src),
    .grp_o  (grp),
    .rest_o (rest)
  );

  mram_wr_verify #(.DATA_W(DATA_W)) u_vfy (
    .act_i   (act_q),
    .rdata_i (arr_rdata_i),
    .pol_i   (pol_q),
    .fail_o  (vfy_fail),
    .pass_o  (vfy_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      pend0_q <= '0;
      pend1_q <= '0;
      act_q   <= '0;
      fail_q  <= '0;
      max_q   <= ONE_PULSE;
      tries_q <= '0;
      vsel0_q <= '0;
      vsel1_q <= '0;
      pol_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_i) begin
            addr_q  <= req_addr_i;
            data_q  <= req_data_i;
            max_q   <= (cfg_max_pulse_i == '0) ? ONE_PULSE : cfg_max_pulse_i;
            vsel0_q <= cfg_vsel_w0_i;
            vsel1_q <= cfg_vsel_w1_i;
            err_q   <= 1'b0;
            fail_q  <= '0;
            state_q <= S_READ;
          end
        end
        S_READ: begin
          if (arr_ack_i) begin
            pend0_q <= clr_mask;
            pend1_q <= set_mask;
            pol_q   <= ~|clr_mask;  // skip straight to polarity 1 if nothing clears
            if (no_change) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_PICK;
            end
          end
        end
        S_PICK: begin
          act_q   <= grp;
          tries_q <= '0;
          if (pol_q) pend1_q <= rest;
          else       pend0_q <= rest;
          state_q <= S_PULSE;
        end
        S_PULSE: begin
          if (arr_ack_i) begin
            tries_q <= tries_q + ONE_PULSE;
            state_q <= S_VERIFY;
          end
        end
        S_VERIFY: begin
          if (arr_ack_i) begin
            if (vfy_pass) begin
              if (!pol_q && (pend0_q != '0)) begin
                state_q <= S_PICK;
              end else if (pend1_q != '0) begin
                pol_q   <= 1'b1;
                state_q <= S_PICK;
              end else begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
            end else if (tries_q >= max_q) begin
              err_q   <= 1'b1;
              fail_q  <= vfy_fail;
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              act_q   <= vfy_fail;  // retry only what failed
              state_q <= S_PULSE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_READ:   cmd = CMD_READ;
      S_PULSE:  cmd = CMD_PULSE;
      S_VERIFY: cmd = CMD_VERIFY;
      default:  cmd = CMD_IDLE;
    endcase
  end

  assign pulsing     = (state_q == S_PULSE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign fail_mask_o = fail_q;
  assign arr_cmd_o   = cmd;
  assign arr_addr_o  = addr_q;
  assign arr_mask_o  = pulsing ? act_q : '0;
  assign arr_pol_o   = pulsing & pol_q;
  assign arr_bl_o    = pulsing & ~pol_q;
  assign arr_sl_o    = pulsing & pol_q;
  assign arr_vsel_o  = pulsing ? (pol_q ? vsel1_q : vsel0_q) : '0;
endmodule

// File: rtl/mram_wr_ctrl_chk.sv
module mram_wr_ctrl_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned GRP_MAX = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] fail_mask_o,
  input logic [1:0]        arr_cmd_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic [DATA_W-1:0] arr_mask_o,
  input logic              arr_pol_o,
  input logic              arr_bl_o,
  input logic              arr_sl_o,
  input logic              arr_ack_i
);
  logic seen_pol1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                seen_pol1_q <= 1'b0;
    else if (done_o)                            seen_pol1_q <= 1'b0;
    else if (arr_cmd_o == 2'd2 && arr_pol_o)    seen_pol1_q <= 1'b1;
  end

  AST_READ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> arr_cmd_o == 2'd1); // R1

  AST_DRIVE_W0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o == 2'd2 && !arr_pol_o) |-> (arr_bl_o && !arr_sl_o)); // R3

  AST_DRIVE_W1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o == 2'd2 && arr_pol_o) |-> (arr_sl_o && !arr_bl_o)); // R4

  AST_POL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o == 2'd2 && seen_pol1_q) |-> arr_pol_o); // R6

  AST_GRP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_cmd_o == 2'd2 |-> (arr_mask_o != '0 && $countones(arr_mask_o) <= GRP_MAX)); // R7

  AST_PULSE_VERIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o == 2'd2 && arr_ack_i) |=> arr_cmd_o == 2'd3); // R8

  AST_OK_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> fail_mask_o == '0); // R10

  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o != 2'd0 && !arr_ack_i) |=>
      ($stable(arr_cmd_o) && $stable(arr_mask_o) && $stable(arr_pol_o) && $stable(arr_addr_o))); // R12

  AST_BUSY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_cmd_o != 2'd0 |-> busy_o); // R13

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R13
endmodule

bind mram_wr_ctrl mram_wr_ctrl_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .GRP_MAX(GRP_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .fail_mask_o (fail_mask_o),
  .arr_cmd_o   (arr_cmd_o),
  .arr_addr_o  (arr_addr_o),
  .arr_mask_o  (arr_mask_o),
  .arr_pol_o   (arr_pol_o),
  .arr_bl_o    (arr_bl_o),
  .arr_sl_o    (arr_sl_o),
  .arr_ack_i   (arr_ack_i)
);

// File: tb/mram_wr_ctrl_tb.sv
module mram_wr_ctrl_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int GM = 3;
  localparam int PW = 4;
  localparam int VW = 4;
  localparam int MAXLOG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [PW-1:0] cfg_maxp;
  logic [VW-1:0] cfg_w0, cfg_w1;
  logic          busy, done, err;
  logic [DW-1:0] fail_mask;
  logic [1:0]    cmd;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_mask;
  logic          a_pol, a_bl, a_sl;
  logic [VW-1:0] a_vsel;
  logic          ack;
  logic [DW-1:0] rdata;

  mram_wr_ctrl #(.DATA_W(DW), .ADDR_W(AW), .GRP_MAX(GM), .PULSE_W(PW), .VSEL_W(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr), .req_data_i(req_data),
    .cfg_max_pulse_i(cfg_maxp), .cfg_vsel_w0_i(cfg_w0), .cfg_vsel_w1_i(cfg_w1),
    .busy_o(busy), .done_o(done), .err_o(err), .fail_mask_o(fail_mask),
    .arr_cmd_o(cmd), .arr_addr_o(a_addr), .arr_mask_o(a_mask), .arr_pol_o(a_pol),
    .arr_bl_o(a_bl), .arr_sl_o(a_sl), .arr_vsel_o(a_vsel), .arr_ack_i(ack), .arr_rdata_i(rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // array word model: each cell flips after need[b] pulses
  logic [DW-1:0] mem [1<<AW];
  int need [DW];
  int hits [DW];
  int lat = 0;
  int wcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      wcnt  <= 0;
      rdata <= '0;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (cmd != 2'd0) begin
      if (wcnt >= lat) begin
        wcnt <= 0;
        ack  <= 1'b1;
        if (cmd == 2'd2) begin
          for (int b = 0; b < DW; b++) begin
            if (a_mask[b]) begin
              hits[b] = hits[b] + 1;
              if (hits[b] >= need[b]) mem[a_addr][b] = a_pol;
            end
          end
        end else begin
          rdata <= mem[a_addr];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // command log
  int            lg_n = 0;
  logic [1:0]    lg_cmd  [MAXLOG];
  logic [DW-1:0] lg_mask [MAXLOG];
  logic          lg_pol  [MAXLOG];
  logic [AW-1:0] lg_addr [MAXLOG];
  bit            in_cmd = 0;
  logic [1:0]    h_cmd;
  logic [DW-1:0] h_mask;
  logic          h_pol;
  logic [VW-1:0] cur_w0, cur_w1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) begin
        in_cmd = 0;
      end else if (cmd != 2'd0) begin
        if (!in_cmd) begin
          in_cmd = 1;
          h_cmd = cmd; h_mask = a_mask; h_pol = a_pol;
          if (lg_n < MAXLOG) begin
            lg_cmd[lg_n] = cmd; lg_mask[lg_n] = a_mask;
            lg_pol[lg_n] = a_pol; lg_addr[lg_n] = a_addr;
          end
          lg_n++;
          chk(busy, "R13 busy during command", {31'd0, busy}, 1);
          if (cmd == 2'd2) begin
            if (!a_pol)
              chk(a_bl && !a_sl && a_vsel == cur_w0, "R3 write-0 drive",
                  {a_bl, a_sl, 26'd0, a_vsel}, {2'b10, 26'd0, cur_w0});
            else
              chk(!a_bl && a_sl && a_vsel == cur_w1, "R4 write-1 drive",
                  {a_bl, a_sl, 26'd0, a_vsel}, {2'b01, 26'd0, cur_w1});
          end
        end else begin
          chk(cmd == h_cmd && a_mask == h_mask && a_pol == h_pol, "R12 command held",
              {cmd, 7'd0, a_pol, 14'd0, a_mask}, {h_cmd, 7'd0, h_pol, 14'd0, h_mask});
        end
      end
    end
  end

  // expected sequence
  int            e_n;
  logic          e_pol  [MAXLOG];
  logic [DW-1:0] e_mask [MAXLOG];
  bit            e_err;
  logic [DW-1:0] e_fail, e_mem;

  task automatic predict(input logic [DW-1:0] old_v, input logic [DW-1:0] new_v, input logic [PW-1:0] maxp);
    int ehits [DW];
    int mx;
    logic [DW-1:0] pend, grp, act, fl;
    e_n = 0; e_err = 0; e_fail = '0; e_mem = old_v;
    for (int b = 0; b < DW; b++) ehits[b] = 0;
    mx = (maxp == 0) ? 1 : int'(maxp);
    for (int p = 0; p < 2; p++) begin
      pend = (p == 0) ? (old_v & ~new_v) : (~old_v & new_v);
      while (pend != '0 && !e_err) begin
        int c = 0;
        int tries = 0;
        grp = '0;
        for (int b = 0; b < DW; b++)
          if (pend[b] && c < GM) begin grp[b] = 1'b1; c++; end
        pend &= ~grp;
        act = grp;
        while (1) begin
          if (e_n < MAXLOG) begin e_pol[e_n] = p[0]; e_mask[e_n] = act; end
          e_n++;
          tries++;
          for (int b = 0; b < DW; b++)
            if (act[b]) begin
              ehits[b]++;
              if (ehits[b] >= need[b]) e_mem[b] = p[0];
            end
          fl = act & (p[0] ? ~e_mem : e_mem);
          if (fl == '0) break;
          if (tries >= mx) begin e_err = 1; e_fail = fl; break; end
          act = fl;
        end
      end
      if (e_err) break;
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] old_v, input logic [DW-1:0] new_v,
                        input logic [PW-1:0] maxp, input int lt, input string tag);
    int t = 0;
    mem[a] = old_v;
    for (int b = 0; b < DW; b++) hits[b] = 0;
    lat = lt;
    predict(old_v, new_v, maxp);
    @(negedge clk);
    lg_n = 0;
    cur_w0 = VW'(lt + 3);
    cur_w1 = VW'(lt + 9);
    req = 1'b1; req_addr = a; req_data = new_v;
    cfg_maxp = maxp; cfg_w0 = cur_w0; cfg_w1 = cur_w1;
    @(negedge clk);
    req = 1'b0;
    // scramble config after acceptance: must be latched (R9, R3, R4)
    cfg_maxp = ~maxp; cfg_w0 = ~cur_w0; cfg_w1 = ~cur_w1; req_data = ~new_v;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, {tag, " completion"}, t, 0);
    chk(err == e_err, {tag, " error flag"}, {31'd0, err}, {31'd0, e_err});
    chk(fail_mask == e_fail, "R10 fail mask", fail_mask, e_fail);
    chk(lg_n == 1 + 2 * e_n, "R8 command count", lg_n, 1 + 2 * e_n);
    chk(lg_n > 0 && lg_cmd[0] == 2'd1 && lg_addr[0] == a, "R1 read first",
        {lg_cmd[0], 26'd0, lg_addr[0]}, {2'd1, 26'd0, a});
    if (lg_n == 1 + 2 * e_n && lg_n <= MAXLOG) begin
      for (int k = 0; k < e_n; k++) begin
        chk(lg_cmd[1 + 2 * k] == 2'd2 && lg_cmd[2 + 2 * k] == 2'd3, "R8 pulse then verify",
            {lg_cmd[1 + 2 * k], lg_cmd[2 + 2 * k]}, 4'b1011);
        chk(lg_pol[1 + 2 * k] == e_pol[k], "R6 polarity order", lg_pol[1 + 2 * k], e_pol[k]);
        chk(lg_mask[1 + 2 * k] == e_mask[k], "R5 R7 pulse mask", lg_mask[1 + 2 * k], e_mask[k]);
      end
    end
    if (!e_err) chk(mem[a] == new_v, "R11 array holds data", mem[a], new_v);
    chk(!busy, "R13 idle at done", {31'd0, busy}, 0);
    @(negedge clk);
    chk(!done, "R11 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req = 1'b0; req_addr = '0; req_data = '0;
    cfg_maxp = '0; cfg_w0 = '0; cfg_w1 = '0;
    cur_w0 = '0; cur_w1 = '0;
    for (int b = 0; b < DW; b++) begin need[b] = 1; hits[b] = 0; end
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && cmd == 2'd0 && !a_bl && !a_sl && a_mask == '0,
        "R13 reset state", {busy, done, err, cmd, a_bl, a_sl}, 0);

    // R2: unchanged word, no pulses
    run_op(4'h3, 8'hA5, 8'hA5, 4'd2, 1, "R2");
    chk(lg_n == 1, "R2 no pulse issued", lg_n, 1);
    run_op(4'h0, 8'h00, 8'h00, 4'd0, 0, "R2");

    // R7: all bits change, groups of three from the bottom
    run_op(4'h1, 8'hFF, 8'h00, 4'd1, 0, "R7");
    run_op(4'h2, 8'h00, 8'hFF, 4'd1, 2, "R7");

    // sweep of old/new pairs, single-pulse cells
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_op(AW'(i ^ j), DW'(i * 37 + 5), DW'(j * 73 + 11), 4'd2, (i + j) % 3, "R11");

    // R9: slow cells, enough budget
    for (int b = 0; b < DW; b++) need[b] = b % 3 + 1;
    run_op(4'h4, 8'h0F, 8'hF0, 4'd3, 1, "R9");
    run_op(4'h5, 8'hC3, 8'h3C, 4'd5, 0, "R9");
    // R9: budget too small
    run_op(4'h6, 8'h0F, 8'hF0, 4'd2, 0, "R9");
    // R9: budget 0 acts as 1
    run_op(4'h7, 8'hF0, 8'h0F, 4'd0, 2, "R9");

    // R10: stuck cell in polarity-0 phase stops before polarity 1
    for (int b = 0; b < DW; b++) need[b] = 1;
    need[5] = 9;
    run_op(4'h8, 8'hF0, 8'h0F, 4'd4, 1, "R10");
    chk(lg_n == 1 + 2 * e_n && e_err, "R10 no polarity-1 work after error", lg_n, 1 + 2 * e_n);
    // R10: stuck cell in polarity-1 phase
    need[5] = 1; need[2] = 7;
    run_op(4'h9, 8'hF0, 8'h0F, 4'd3, 0, "R10");
    for (int b = 0; b < DW; b++) need[b] = 1;
    run_op(4'hA, 8'h81, 8'h7E, 4'd1, 1, "R11");

    finish_run();
  end
endmodule